// File: doc/BRIEF.md
# Bidirectional Flyback Cell Balancer Gate Sequencer

This block sequences the two switch enables of each of several synchronous flyback cell-balancing channels (six by default). A channel commanded to discharge pulls energy out of its cell: the primary-side switch conducts first, and the secondary-side switch then returns the energy to the stack. A channel commanded to charge runs the same two phases in the opposite order. Each conducting phase ends on its comparator flag or on a programmable on-time clamp, whichever comes first. A one-cycle dead gap separates every phase from the next, and the two-phase cycle repeats for as long as the command stays active.

All channels run at once, in any mix of idle, charge and discharge. A command strobe loads the mode of every channel together and restarts a shared watchdog. Cell undervoltage, cell overvoltage and secondary overvoltage inputs, together with watchdog expiry, set sticky fault bits. While any of these bits is set or any fault input is high, every channel is held idle, all pending commands are discarded and new commands are refused. The fault bits stay set until an explicit clear.

Top module: `cell_xfer_sequencer`

## Requirements
- R1: After reset all gate enables are low and `fault_status` is 4'b0000.
- R2: Discharge (mode 2'b10) turns the primary on until `pri_peak` is sampled high or its clamp expires. One idle cycle follows, then the secondary turns on until `sec_zero` is sampled high or its clamp expires. One idle cycle follows, and the cycle repeats. `sec_peak` and `pri_zero` have no effect in this mode.
- R3: Charge (mode 2'b01) turns the secondary on first, until `sec_peak` is sampled high or its clamp expires. The primary then conducts until `pri_zero` is sampled high or its clamp expires, with the same idle cycles between phases. `pri_peak` and `sec_zero` have no effect in this mode.
- R4: A primary phase lasts at most max(`cfg_pri_max`,1) cycles and a secondary phase at most max(`cfg_sec_max`,1) cycles. Both limits are loaded together when `cfg_we` is high.
- R5: The primary and secondary enables of a channel are never high together, and every phase is followed by exactly one cycle with both enables low.
- R6: Channel i takes its mode from `cmd_mode[2i+1:2i]`: 2'b00 is idle, 2'b01 is charge, 2'b10 is discharge and 2'b11 is idle. All fields load on a `cmd_valid` cycle, and the first phase is on in the second cycle after the strobe.
- R7: A new active mode takes effect only after the current cycle's second phase and its idle cycle. A change to idle turns the gates off one cycle after the strobe cycle.
- R8: A high `cell_uv`, `cell_ov` or `sec_ov` sets `fault_status` bit 0, 1 or 2 at the next edge and turns off every gate from that same edge. It also discards all loaded commands.
- R9: If no `cmd_valid` arrives for `WD_CYCLES` cycles, `fault_status` bit 3 sets, and the gates turn off one cycle later.
- R10: Fault bits stay set until `flt_clr`. A fault input that is high in the clear cycle wins. While any fault bit is set, `cmd_valid` is ignored and no channel starts.
- R11: Channels run concurrently and independently, each following its own mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe: loads all modes, restarts watchdog |
| cmd_mode | input | 2*N_CH | Per-channel mode fields |
| cfg_we | input | 1 | Loads both on-time limits |
| cfg_pri_max | input | CNT_W | Primary on-time limit in cycles |
| cfg_sec_max | input | CNT_W | Secondary on-time limit in cycles |
| pri_peak | input | N_CH | Primary peak-current flags |
| pri_zero | input | N_CH | Primary zero-current flags |
| sec_peak | input | N_CH | Secondary peak-current flags |
| sec_zero | input | N_CH | Secondary zero-current flags |
| cell_uv | input | 1 | Cell undervoltage |
| cell_ov | input | 1 | Cell overvoltage |
| sec_ov | input | 1 | Transformer secondary overvoltage |
| flt_clr | input | 1 | Clears latched fault bits |
| pri_gate | output | N_CH | Primary switch enables |
| sec_gate | output | N_CH | Secondary switch enables |
| fault_status | output | 4 | Latched faults {wd, sec_ov, cell_ov, cell_uv} |

## Verification
The bench sweeps both clamp limits from zero upwards in both directions. A zero limit handled as a full counter wrap, or an off-by-one clamp, shows up as a wrong pulse width or a wrong period. Flag tests hold the terminating flag of each winding high, and separately hold the flags of the other direction high. Decoding a flag for the wrong phase would stretch or cut pulses. A mode change issued in mid-cycle checks that the running cycle completes before the order reverses, and a stop checks that the gates fall immediately. Fault tests check that the gates die at once and that bits stay latched and survive a clear that collides with a live fault. They also check that refused and discarded commands never restart a channel, and that the watchdog fires on exactly the right cycle.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'b00,
    MODE_CHG  = 2'b01,
    MODE_DIS  = 2'b10,
    MODE_RSV  = 2'b11
  } mode_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_FIRST,
    PH_GAP,
    PH_SECOND,
    PH_GAP2
  } phase_e;

  localparam int FLT_UV  = 0;
  localparam int FLT_OV  = 1;
  localparam int FLT_SOV = 2;
  localparam int FLT_WD  = 3;
  localparam int FLT_W   = 4;

endpackage

// File: rtl/xfer_fault_ctrl.sv
module xfer_fault_ctrl
  import xfer_pkg::*;
#(
  parameter int WD_CYCLES = 50000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             cell_uv,
  input  logic             cell_ov,
  input  logic             sec_ov,
  input  logic             flt_clr,
  output logic [FLT_W-1:0] status,
  output logic             fault_any
);

  localparam int WDW = $clog2(WD_CYCLES + 1);
  localparam logic [WDW-1:0] WD_LAST = WDW'(WD_CYCLES - 1);
  localparam logic [WDW-1:0] WD_TOP  = WDW'(WD_CYCLES);

  logic [WDW-1:0]   wd_cnt_q;
  logic             wd_fire;
  logic [FLT_W-1:0] raw;
  logic [FLT_W-1:0] status_q;

  // watchdog: restarted by any strobe or clear, saturates at the limit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_cnt_q <= '0;
    end else if (cmd_valid || flt_clr) begin
      wd_cnt_q <= '0;
    end else if (wd_cnt_q != WD_TOP) begin
      wd_cnt_q <= wd_cnt_q + 1'b1;
    end
  end

  assign wd_fire = (wd_cnt_q == WD_LAST) && !cmd_valid && !flt_clr;

  always_comb begin
    raw          = '0;
    raw[FLT_UV]  = cell_uv;
    raw[FLT_OV]  = cell_ov;
    raw[FLT_SOV] = sec_ov;
    raw[FLT_WD]  = wd_fire;
  end

  // sticky bits: a live source wins over a clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
    end else begin
      status_q <= raw | (status_q & {FLT_W{~flt_clr}});
    end
  end

  assign status    = status_q;
  assign fault_any = (|status_q) | cell_uv | cell_ov | sec_ov;

  assert_wd_bound_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    wd_cnt_q <= WD_TOP);

  generate
    for (genvar b = 0; b < FLT_W; b++) begin : g_sticky
      assert_sticky_R10 : assert property (@(posedge clk) disable iff (!rst_n)
        ($past(status_q[b]) && !$past(flt_clr)) |-> status_q[b]);
    end
  endgenerate

endmodule

// File: rtl/xfer_cmd_regs.sv
module xfer_cmd_regs
  import xfer_pkg::*;
#(
  parameter int N_CH    = 6,
  parameter int CNT_W   = 8,
  parameter int PRI_RST = 16,
  parameter int SEC_RST = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fault_any,
  input  logic               cmd_valid,
  input  logic [2*N_CH-1:0]  cmd_mode,
  input  logic               cfg_we,
  input  logic [CNT_W-1:0]   cfg_pri_max,
  input  logic [CNT_W-1:0]   cfg_sec_max,
  output logic [2*N_CH-1:0]  req_mode,
  output logic [CNT_W-1:0]   pri_lim,
  output logic [CNT_W-1:0]   sec_lim
);

  logic [2*N_CH-1:0] req_q;
  logic [CNT_W-1:0]  pri_q;
  logic [CNT_W-1:0]  sec_q;

  // a fault flushes every pending command and refuses new ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
    end else if (fault_any) begin
      req_q <= '0;
    end else if (cmd_valid) begin
      req_q <= cmd_mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_q <= CNT_W'(PRI_RST);
      sec_q <= CNT_W'(SEC_RST);
    end else if (cfg_we) begin
      pri_q <= cfg_pri_max;
      sec_q <= cfg_sec_max;
    end
  end

  assign req_mode = req_q;
  assign pri_lim  = pri_q;
  assign sec_lim  = sec_q;

endmodule

// File: rtl/xfer_channel.sv
module xfer_channel
  import xfer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt,
  input  mode_e            req_mode,
  input  logic [CNT_W-1:0] pri_lim,
  input  logic [CNT_W-1:0] sec_lim,
  input  logic             pri_peak,
  input  logic             pri_zero,
  input  logic             sec_peak,
  input  logic             sec_zero,
  output logic             pri_gate,
  output logic             sec_gate
);

  phase_e           st_q, st_d;
  mode_e            cur_q, cur_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  logic             req_run;
  logic             dis;
  logic [CNT_W-1:0] lim_now;
  logic             end_flag;
  logic             clamp_hit;
  logic             phase_done;

  assign req_run = (req_mode == MODE_CHG) || (req_mode == MODE_DIS);
  assign dis     = (cur_q == MODE_DIS);

  // discharge: primary leads; charge: secondary leads
  always_comb begin
    if (st_q == PH_FIRST) begin
      lim_now  = dis ? pri_lim  : sec_lim;
      end_flag = dis ? pri_peak : sec_peak;
    end else begin
      lim_now  = dis ? sec_lim  : pri_lim;
      end_flag = dis ? sec_zero : pri_zero;
    end
  end

  assign clamp_hit  = ({1'b0, cnt_q} + 1'b1) >= {1'b0, lim_now};
  assign phase_done = clamp_hit || end_flag;

  always_comb begin
    st_d  = st_q;
    cur_d = cur_q;
    cnt_d = cnt_q;
    if (halt || !req_run) begin
      st_d  = PH_IDLE;
      cur_d = MODE_IDLE;
      cnt_d = '0;
    end else begin
      case (st_q)
        PH_IDLE: begin
          st_d  = PH_FIRST;
          cur_d = req_mode;
          cnt_d = '0;
        end
        PH_FIRST: begin
          if (phase_done) begin
            st_d  = PH_GAP;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_GAP: begin
          st_d = PH_SECOND;
        end
        PH_SECOND: begin
          if (phase_done) begin
            st_d  = PH_GAP2;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_GAP2: begin
          // the only point where a new active mode is adopted
          st_d  = PH_FIRST;
          cur_d = req_mode;
          cnt_d = '0;
        end
        default: begin
          st_d  = PH_IDLE;
          cur_d = MODE_IDLE;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PH_IDLE;
      cur_q <= MODE_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cur_q <= cur_d;
      cnt_q <= cnt_d;
    end
  end

  assign pri_gate = ((st_q == PH_FIRST) && (cur_q == MODE_DIS)) ||
                    ((st_q == PH_SECOND) && (cur_q == MODE_CHG));
  assign sec_gate = ((st_q == PH_FIRST) && (cur_q == MODE_CHG)) ||
                    ((st_q == PH_SECOND) && (cur_q == MODE_DIS));

  assert_one_switch_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    !(pri_gate && sec_gate));

  assert_dead_pri_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pri_gate) |-> !sec_gate);

  assert_dead_sec_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sec_gate) |-> !pri_gate);

  assert_clamp_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    (pri_gate || sec_gate) |-> (cnt_q < ((lim_now == '0) ? CNT_W'(1) : lim_now)));

  assert_mode_hold_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q != PH_IDLE) && ($past(st_q) != PH_GAP2) && ($past(st_q) != PH_IDLE))
      |-> $stable(cur_q));

endmodule

// File: rtl/cell_xfer_sequencer.sv
module cell_xfer_sequencer
  import xfer_pkg::*;
#(
  parameter int N_CH      = 6,
  parameter int CNT_W     = 8,
  parameter int WD_CYCLES = 50000,
  parameter int PRI_RST   = 16,
  parameter int SEC_RST   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2*N_CH-1:0] cmd_mode,
  input  logic              cfg_we,
  input  logic [CNT_W-1:0]  cfg_pri_max,
  input  logic [CNT_W-1:0]  cfg_sec_max,
  input  logic [N_CH-1:0]   pri_peak,
  input  logic [N_CH-1:0]   pri_zero,
  input  logic [N_CH-1:0]   sec_peak,
  input  logic [N_CH-1:0]   sec_zero,
  input  logic              cell_uv,
  input  logic              cell_ov,
  input  logic              sec_ov,
  input  logic              flt_clr,
  output logic [N_CH-1:0]   pri_gate,
  output logic [N_CH-1:0]   sec_gate,
  output logic [3:0]        fault_status
);

  logic              fault_any;
  logic [2*N_CH-1:0] req_mode;
  logic [CNT_W-1:0]  pri_lim;
  logic [CNT_W-1:0]  sec_lim;
  logic [FLT_W-1:0]  status;

  xfer_fault_ctrl #(
    .WD_CYCLES (WD_CYCLES)
  ) u_fault (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cell_uv   (cell_uv),
    .cell_ov   (cell_ov),
    .sec_ov    (sec_ov),
    .flt_clr   (flt_clr),
    .status    (status),
    .fault_any (fault_any)
  );

  xfer_cmd_regs #(
    .N_CH    (N_CH),
    .CNT_W   (CNT_W),
    .PRI_RST (PRI_RST),
    .SEC_RST (SEC_RST)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .fault_any   (fault_any),
    .cmd_valid   (cmd_valid),
    .cmd_mode    (cmd_mode),
    .cfg_we      (cfg_we),
    .cfg_pri_max (cfg_pri_max),
    .cfg_sec_max (cfg_sec_max),
    .req_mode    (req_mode),
    .pri_lim     (pri_lim),
    .sec_lim     (sec_lim)
  );

  generate
    for (genvar i = 0; i < N_CH; i++) begin : g_ch
      xfer_channel #(
        .CNT_W (CNT_W)
      ) u_ch (
        .clk      (clk),
        .rst_n    (rst_n),
        .halt     (fault_any),
        .req_mode (mode_e'(req_mode[2*i +: 2])),
        .pri_lim  (pri_lim),
        .sec_lim  (sec_lim),
        .pri_peak (pri_peak[i]),
        .pri_zero (pri_zero[i]),
        .sec_peak (sec_peak[i]),
        .sec_zero (sec_zero[i]),
        .pri_gate (pri_gate[i]),
        .sec_gate (sec_gate[i])
      );
    end
  endgenerate

  assign fault_status = status;

  assert_halt_off_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    fault_any |=> ((pri_gate == '0) && (sec_gate == '0)));

  assert_no_start_R10 : assert property (@(posedge clk) disable iff (!rst_n)
    ((|status) && (pri_gate == '0) && (sec_gate == '0))
      |=> ((pri_gate == '0) && (sec_gate == '0)));

endmodule

// File: tb/cell_xfer_sequencer_tb_top.sv
module cell_xfer_sequencer_tb_top;

  localparam int N  = 6;
  localparam int CW = 4;
  localparam int WD = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [2*N-1:0] cmd_mode = '0;
  logic          cfg_we = 1'b0;
  logic [CW-1:0] cfg_pri_max = '0;
  logic [CW-1:0] cfg_sec_max = '0;
  logic [N-1:0]  pri_peak = '0;
  logic [N-1:0]  pri_zero = '0;
  logic [N-1:0]  sec_peak = '0;
  logic [N-1:0]  sec_zero = '0;
  logic          cell_uv = 1'b0;
  logic          cell_ov = 1'b0;
  logic          sec_ov = 1'b0;
  logic          flt_clr = 1'b0;
  logic [N-1:0]  pri_gate;
  logic [N-1:0]  sec_gate;
  logic [3:0]    fault_status;

  int n_checks = 0;
  int n_fails  = 0;

  always #2 clk = ~clk;

  cell_xfer_sequencer #(
    .N_CH      (N),
    .CNT_W     (CW),
    .WD_CYCLES (WD),
    .PRI_RST   (3),
    .SEC_RST   (3)
  ) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_mode     (cmd_mode),
    .cfg_we       (cfg_we),
    .cfg_pri_max  (cfg_pri_max),
    .cfg_sec_max  (cfg_sec_max),
    .pri_peak     (pri_peak),
    .pri_zero     (pri_zero),
    .sec_peak     (sec_peak),
    .sec_zero     (sec_zero),
    .cell_uv      (cell_uv),
    .cell_ov      (cell_ov),
    .sec_ov       (sec_ov),
    .flt_clr      (flt_clr),
    .pri_gate     (pri_gate),
    .sec_gate     (sec_gate),
    .fault_status (fault_status)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic strobe(input logic [2*N-1:0] v);
    cmd_mode  = v;
    cmd_valid = 1'b1;
    tick();
    cmd_valid = 1'b0;
  endtask

  task automatic load_cfg(input int p, input int s);
    cfg_pri_max = CW'(p);
    cfg_sec_max = CW'(s);
    cfg_we = 1'b1;
    tick();
    cfg_we = 1'b0;
  endtask

  // expected {pri,sec} at phase position t; pw/sw are primary/secondary widths
  function automatic logic [1:0] exp_gates(input int md, input int t, input int pw, input int sw);
    int fw, w2, per, p;
    logic a, b;
    if (md != 1 && md != 2) return 2'b00;
    fw  = (md == 2) ? pw : sw;
    w2  = (md == 2) ? sw : pw;
    per = fw + w2 + 2;
    p   = t % per;
    a   = (p < fw);
    b   = (p >= fw + 1) && (p < fw + 1 + w2);
    return (md == 2) ? {a, b} : {b, a};
  endfunction

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  // single-channel run: strobe mode, compare two full periods, then stop
  task automatic run_pattern(input int md, input int ch, input int p, input int s,
                             input int pw, input int sw, input string req);
    logic [2*N-1:0] v;
    int errs, per, fa, fe;
    logic [1:0] g, e;
    v = '0;
    v[2*ch +: 2] = md[1:0];
    load_cfg(p, s);
    strobe(v);
    errs = 0; fa = 0; fe = 0;
    if (pri_gate != '0 || sec_gate != '0) errs++;
    per = pw + sw + 2;
    for (int t = 0; t < 2 * per; t++) begin
      tick();
      g = {pri_gate[ch], sec_gate[ch]};
      e = exp_gates(md, t, pw, sw);
      if (g != e && errs == 0) begin fa = g; fe = e; end
      if (g != e) errs++;
    end
    check(errs == 0, req, fa, fe);
    strobe('0);
    tick();
    check(pri_gate == '0 && sec_gate == '0, "R7 stop", int'({pri_gate, sec_gate}), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: run did not finish actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    check(pri_gate == '0 && sec_gate == '0, "R1 gates", int'({pri_gate, sec_gate}), 0);
    check(fault_status == 4'b0000, "R1 status", int'(fault_status), 0);
    rst_n = 1'b1;
    tick();

    // R2 R3 R4 R5 R6: clamp sweep, no flags
    for (int p = 0; p < 5; p++) begin
      for (int s = 0; s < 5; s++) begin
        run_pattern(2, (p + s) % N, p, s, eff(p), eff(s), "R2 R4 R5 discharge clamp sweep");
        run_pattern(1, (p + 2 * s) % N, p, s, eff(p), eff(s), "R3 R4 R5 charge clamp sweep");
      end
    end
    check(fault_status == 4'b0000, "R9 no expiry while strobed", int'(fault_status), 0);

    // R2 flag-terminated discharge phases
    pri_peak = '1; sec_zero = '1;
    run_pattern(2, 1, 5, 5, 1, 1, "R2 flag end discharge");
    // R3 flags of discharge direction have no effect on charge
    run_pattern(1, 2, 3, 4, 3, 4, "R3 foreign flags ignored");
    pri_peak = '0; sec_zero = '0;
    sec_peak = '1; pri_zero = '1;
    run_pattern(1, 3, 5, 5, 1, 1, "R3 flag end charge");
    run_pattern(2, 4, 4, 3, 4, 3, "R2 foreign flags ignored");
    sec_peak = '0; pri_zero = '0;

    // R6: reserved code 2'b11 behaves as idle
    begin
      logic [2*N-1:0] v;
      v = '0; v[1:0] = 2'b11;
      strobe(v);
      tick(); tick();
      check(pri_gate == '0 && sec_gate == '0, "R6 reserved idle", int'({pri_gate, sec_gate}), 0);
    end

    // R11 concurrent channels in mixed modes
    begin
      int md [N];
      int errs [N];
      logic [2*N-1:0] v;
      md[0] = 2; md[1] = 1; md[2] = 2; md[3] = 1; md[4] = 0; md[5] = 2;
      v = '0;
      for (int i = 0; i < N; i++) begin v[2*i +: 2] = md[i][1:0]; errs[i] = 0; end
      load_cfg(2, 3);
      strobe(v);
      for (int t = 0; t < 14; t++) begin
        tick();
        for (int i = 0; i < N; i++)
          if ({pri_gate[i], sec_gate[i]} != exp_gates(md[i], t, 2, 3)) errs[i]++;
      end
      for (int i = 0; i < N; i++) check(errs[i] == 0, "R11 concurrent channel", errs[i], 0);

      // R8 overvoltage kills every gate at once
      cell_ov = 1'b1;
      tick();
      cell_ov = 1'b0;
      check(pri_gate == '0 && sec_gate == '0, "R8 gates off", int'({pri_gate, sec_gate}), 0);
      check(fault_status == 4'b0010, "R8 ov bit", int'(fault_status), 2);
      tick();
      check(fault_status == 4'b0010, "R10 sticky", int'(fault_status), 2);
      strobe(v);
      tick(); tick();
      check(pri_gate == '0 && sec_gate == '0, "R10 command ignored", int'({pri_gate, sec_gate}), 0);
      // R10 clear colliding with a live undervoltage
      cell_uv = 1'b1; flt_clr = 1'b1;
      tick();
      cell_uv = 1'b0; flt_clr = 1'b0;
      check(fault_status == 4'b0001, "R10 set wins over clear", int'(fault_status), 1);
      flt_clr = 1'b1;
      tick();
      flt_clr = 1'b0;
      check(fault_status == 4'b0000, "R10 cleared", int'(fault_status), 0);
      tick(); tick();
      check(pri_gate == '0 && sec_gate == '0, "R8 commands discarded", int'({pri_gate, sec_gate}), 0);
      // R8 secondary overvoltage bit position
      sec_ov = 1'b1;
      tick();
      sec_ov = 1'b0;
      check(fault_status == 4'b0100, "R8 sec ov bit", int'(fault_status), 4);
      flt_clr = 1'b1;
      tick();
      flt_clr = 1'b0;
      // R10 fresh command after clear runs again
      strobe(v);
      tick();
      check(pri_gate[0] == 1'b1 && sec_gate[1] == 1'b1, "R10 resume after clear",
            int'({pri_gate, sec_gate}), 1);
      strobe('0);
    end

    // R7 active mode change waits for cycle end
    begin
      logic [2*N-1:0] v;
      int errs, md;
      load_cfg(3, 3);
      v = '0; v[1:0] = 2'b10;
      strobe(v);
      tick();                     // t=0
      v[1:0] = 2'b01;
      cmd_mode = v; cmd_valid = 1'b1;
      tick();                     // t=1
      cmd_valid = 1'b0;
      errs = 0;
      if ({pri_gate[0], sec_gate[0]} != exp_gates(2, 1, 3, 3)) errs++;
      for (int t = 2; t < 16; t++) begin
        tick();
        md = (t < 8) ? 2 : 1;
        if ({pri_gate[0], sec_gate[0]} != exp_gates(md, t % 8, 3, 3)) errs++;
      end
      check(errs == 0, "R7 change deferred to cycle end", errs, 0);
      strobe('0);
      tick();
    end

    // R7 change to idle is immediate
    load_cfg(5, 5);
    begin
      logic [2*N-1:0] v;
      v = '0; v[1:0] = 2'b10;
      strobe(v);
      tick(); tick();
      cmd_mode = '0; cmd_valid = 1'b1;
      tick();
      cmd_valid = 1'b0;
      check(pri_gate[0] == 1'b1, "R7 still on at stop strobe", int'(pri_gate[0]), 1);
      tick();
      check(pri_gate[0] == 1'b0, "R7 off after stop", int'(pri_gate[0]), 0);
    end

    // R9 watchdog expiry timing
    begin
      logic [2*N-1:0] v;
      v = '0; v[1:0] = 2'b10;
      strobe(v);
      repeat (WD - 1) tick();
      check(fault_status[3] == 1'b0, "R9 not yet expired", int'(fault_status), 0);
      tick();
      check(fault_status == 4'b1000, "R9 expiry bit", int'(fault_status), 8);
      tick();
      check(pri_gate == '0 && sec_gate == '0, "R9 gates off", int'({pri_gate, sec_gate}), 0);
      flt_clr = 1'b1;
      tick();
      flt_clr = 1'b0;
      check(fault_status == 4'b0000, "R10 wd cleared", int'(fault_status), 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule